// File: doc/BRIEF.md
# Front-End Hazard Stall Controller

This block decides, cycle by cycle, whether the front end of a five-stage in-order integer pipeline advances or holds. The pipeline runs IF, ID, EX, MEM, WB. The controller looks at the instruction word held in the IF/ID register and classifies it. From that class it drives three things: the PC write enable, the IF/ID write enable, and a bubble request that replaces the word passed into ID/EX with a harmless no-op.

There is no prediction and no flushing. Any jump or conditional branch is followed by three bubble cycles, taken or not. Any load is followed by one bubble. The forwarding network cannot supply load data, so that single bubble is the only cover for a load-use hazard. Instruction and data memories are separate, so structural hazards never need a stall.

The block also owns the last step of the PC mux. The surrounding pipeline fetches from the next-PC value and captures the fetched word into IF/ID on the same edge that the PC register updates. The PC register therefore always holds the address of the word in ID. On the final bubble cycle of a control transfer, the block releases fetch and steers the PC to the resolved destination. An all-zero instruction word ends the program and freezes fetch until reset.

Top module: `stall_ctl`

## Requirements
- R1: On the first cycle after synchronous reset, with an ordinary instruction in ID, the PC enable and the IF/ID enable are high, the bubble is low, and the halt flag is low.
- R2: A word is treated as a control transfer in three cases: its low seven bits are 1101111; its low seven bits are 1100111 with bits 14:12 equal to 000; or its low seven bits are 1100011 with bits 14:12 any of 000, 001, 100, 101, 110, 111. In the cycle such a word issues from ID, the bubble is low and the word passes to ID/EX unchanged, while both enables are low.
- R3: A control transfer is followed by exactly three bubble cycles. Both enables stay low in the first two of these and go high in the third. The cycle after that is an ordinary issue cycle.
- R4: The branch outcome and destination are sampled from the execute-stage inputs in the first bubble cycle after the transfer issues, and later changes on those inputs are ignored. On the third bubble cycle the next-PC output equals the sampled destination when the outcome was taken. When it was not taken, the next-PC output equals the current PC plus 4.
- R5: A word with low seven bits 0000011 and bits 14:12 any of 000, 001, 010, 100, 101 is a load. In its issue cycle both enables are low and the bubble is low. It is followed by exactly one bubble cycle, in which both enables are high and the next-PC output is PC plus 4.
- R6: Words that match none of the patterns in R2 or R5 cause no stall. This includes a branch opcode with bits 14:12 equal to 010, a load opcode with bits 14:12 equal to 011, the indirect-jump opcode with bits 14:12 not 000, stores and ALU operations.
- R7: The word sent toward ID/EX is 0x00000013 (add-immediate of zero into register zero) whenever the bubble is high. Otherwise it is the word in ID.
- R8: While a stall is running, the word in ID has no effect. A new transfer, a load or an all-zero word neither lengthens the stall nor starts a new one.
- R9: An all-zero word seen in ID outside a stall raises the halt flag from the next cycle. While the flag is high, both enables are low and the bubble is high. The flag stays high until reset.
- R10: In an ordinary issue cycle the next-PC output is the current PC plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_instr | input | 32 | Instruction word held in IF/ID |
| pc_q | input | XLEN | Current PC register, the address of the word in ID |
| ex_taken | input | 1 | Resolved branch outcome from execute |
| ex_target | input | XLEN | Resolved destination from execute |
| pc_we | output | 1 | PC register write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| idex_bubble | output | 1 | Replace the ID/EX input with a no-op |
| ex_instr | output | 32 | Word to capture into ID/EX |
| pc_next | output | XLEN | Next PC value for the PC mux |
| halted | output | 1 | Program-end flag |

## Verification
The bench builds the block with its default stall lengths: three bubble cycles after a transfer and one after a load, at a 32-bit PC. With these values a transfer costs four issue cycles and a load costs two. Every bubble cycle of a stall can be checked one at a time, including the sampling cycle, the cycles in which changes on the execute inputs must be ignored, and the release cycle with the redirected PC. The same stall lengths allow a program-end word and a fresh load to be injected mid-stall, so the bench can show that neither extends the stall nor halts the pipeline.

// File: rtl/stall_ctl_pkg.sv
package stall_ctl_pkg;

    localparam logic [31:0] NOP_WORD = 32'h0000_0013;
    localparam logic [31:0] END_WORD = 32'h0000_0000;

    localparam logic [6:0] OP_JAL  = 7'b1101111;
    localparam logic [6:0] OP_JALR = 7'b1100111;
    localparam logic [6:0] OP_BR   = 7'b1100011;
    localparam logic [6:0] OP_LD   = 7'b0000011;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_XFER  = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_END   = 2'd3
    } iclass_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } fe_ctl_t;

    function automatic iclass_e classify(input logic [31:0] w);
        logic [6:0] op;
        logic [2:0] f3;
        op = w[6:0];
        f3 = w[14:12];
        if (w == END_WORD)
            return CLS_END;
        unique case (op)
            OP_JAL:  return CLS_XFER;
            OP_JALR: return (f3 == 3'b000) ? CLS_XFER : CLS_PLAIN;
            OP_BR:   return (f3[2:1] == 2'b01) ? CLS_PLAIN : CLS_XFER;
            OP_LD:   return (f3 == 3'b011 || f3[2:1] == 2'b11) ? CLS_PLAIN : CLS_LOAD;
            default: return CLS_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/instr_classifier.sv
module instr_classifier
    import stall_ctl_pkg::*;
(
    input  logic [31:0] word,
    output iclass_e     cls
);
    always_comb cls = classify(word);
endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
    parameter int XFER_BUBBLES = 3,
    parameter int LOAD_BUBBLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_xfer,
    input  logic req_load,
    output logic busy,
    output logic last,
    output logic first_xfer,
    output logic kind_xfer
);
    localparam int MAXB = (XFER_BUBBLES > LOAD_BUBBLES) ? XFER_BUBBLES : LOAD_BUBBLES;
    localparam int CW   = $clog2(MAXB + 1);
    localparam logic [CW-1:0] XFER_LD = CW'(XFER_BUBBLES);
    localparam logic [CW-1:0] LOAD_LD = CW'(LOAD_BUBBLES);

    logic [CW-1:0] cnt;
    logic          kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            kind_q <= 1'b0;
        end else if (cnt == '0) begin
            if (req_xfer) begin
                cnt    <= XFER_LD;
                kind_q <= 1'b1;
            end else if (req_load) begin
                cnt    <= LOAD_LD;
                kind_q <= 1'b0;
            end
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy       = (cnt != '0);
    assign last       = (cnt == CW'(1));
    assign kind_xfer  = kind_q;
    assign first_xfer = kind_q && (cnt == XFER_LD);

    // R3: stall counts down one step per cycle
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (cnt > CW'(1)) |=> (cnt == $past(cnt) - 1'b1));
    // R2: an accepted transfer arms the full transfer window
    a_r2_xfer_arm: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_xfer) |=> (cnt == XFER_LD && kind_q));
    // R5: an accepted load arms the load window
    a_r5_load_arm: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_load && !req_xfer) |=> (cnt == LOAD_LD && !kind_q));
    // R8: no request restarts a running stall
    a_r8_no_rearm: assert property (@(posedge clk) disable iff (rst)
        (last) |=> (cnt == '0));
endmodule

// File: rtl/pc_handoff.sv
module pc_handoff #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic            use_tgt,
    input  logic            ex_taken,
    input  logic [XLEN-1:0] ex_target,
    input  logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] pc_next
);
    logic            taken_q;
    logic [XLEN-1:0] tgt_q;
    logic            sel_taken;
    logic [XLEN-1:0] sel_tgt;
    logic [XLEN-1:0] pc_seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            tgt_q   <= '0;
        end else if (capture) begin
            taken_q <= ex_taken;
            tgt_q   <= ex_target;
        end
    end

    always_comb begin
        pc_seq    = pc_q + XLEN'(4);
        sel_taken = capture ? ex_taken  : taken_q;
        sel_tgt   = capture ? ex_target : tgt_q;
        pc_next   = (use_tgt && sel_taken) ? sel_tgt : pc_seq;
    end

    // R4: the resolved outcome is held from the sampling cycle on
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        capture |=> (taken_q == $past(ex_taken) && tgt_q == $past(ex_target)));
    // R4: held values stay put until the next capture
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(taken_q) && $stable(tgt_q)));
endmodule

// File: rtl/stall_ctl.sv
module stall_ctl
    import stall_ctl_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int XFER_BUBBLES = 3,
    parameter int LOAD_BUBBLES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     id_instr,
    input  logic [XLEN-1:0] pc_q,
    input  logic            ex_taken,
    input  logic [XLEN-1:0] ex_target,
    output logic            pc_we,
    output logic            ifid_we,
    output logic            idex_bubble,
    output logic [31:0]     ex_instr,
    output logic [XLEN-1:0] pc_next,
    output logic            halted
);
    iclass_e cls;
    logic    busy, last, first_xfer, kind_xfer;
    logic    halted_q, accept;
    fe_ctl_t ctl;

    instr_classifier u_cls (.word(id_instr), .cls(cls));

    assign accept = !busy && !halted_q;

    stall_timer #(.XFER_BUBBLES(XFER_BUBBLES), .LOAD_BUBBLES(LOAD_BUBBLES)) u_tmr (
        .clk(clk), .rst(rst),
        .req_xfer(accept && cls == CLS_XFER),
        .req_load(accept && cls == CLS_LOAD),
        .busy(busy), .last(last), .first_xfer(first_xfer), .kind_xfer(kind_xfer)
    );

    pc_handoff #(.XLEN(XLEN)) u_pc (
        .clk(clk), .rst(rst),
        .capture(first_xfer), .use_tgt(last && kind_xfer),
        .ex_taken(ex_taken), .ex_target(ex_target),
        .pc_q(pc_q), .pc_next(pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) halted_q <= 1'b0;
        else if (accept && cls == CLS_END) halted_q <= 1'b1;
    end

    always_comb begin
        ctl = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0};
        if (halted_q) begin
            ctl = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b1};
        end else if (busy) begin
            ctl = '{pc_we: last, ifid_we: last, bubble: 1'b1};
        end else begin
            unique case (cls)
                CLS_XFER, CLS_LOAD: ctl = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b0};
                CLS_END:            ctl = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b1};
                default:            ;
            endcase
        end
    end

    assign pc_we       = ctl.pc_we;
    assign ifid_we     = ctl.ifid_we;
    assign idex_bubble = ctl.bubble;
    assign ex_instr    = ctl.bubble ? NOP_WORD : id_instr;
    assign halted      = halted_q;

    // R9: halt is sticky
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    // R9: a halted front end stays frozen
    a_r9_halt_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!pc_we && !ifid_we && idex_bubble));
    // R3: fetch is held in every bubble except the releasing one
    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |-> (!pc_we && !ifid_we));
    // R2: a transfer issue is followed by a bubble
    a_r2_issue_then_bubble: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == CLS_XFER) |=> idex_bubble);
endmodule

// File: tb/sim_stall_ctl.sv
`timescale 1ns/100ps
module sim_stall_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] id_instr, pc_q, ex_target;
    logic        ex_taken;
    logic        pc_we, ifid_we, idex_bubble, halted;
    logic [31:0] ex_instr, pc_next;
    int          n_run = 0, n_fail = 0;

    localparam logic [31:0] NOP  = 32'h0000_0013;
    localparam logic [31:0] ADDI = 32'h0050_0093;
    localparam logic [31:0] PC0  = 32'h0000_0100;

    always #2.5 clk = ~clk;

    stall_ctl u0 (
        .clk(clk), .rst(rst), .id_instr(id_instr), .pc_q(pc_q),
        .ex_taken(ex_taken), .ex_target(ex_target),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
        .ex_instr(ex_instr), .pc_next(pc_next), .halted(halted)
    );

    function automatic logic [31:0] mk(input logic [6:0] op, input logic [2:0] f3);
        return {17'd0, f3, 5'd1, op};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic ctl3(input string req, input logic p, input logic f, input logic b);
        chk(req, "pc_we", {31'd0, pc_we}, {31'd0, p});
        chk(req, "ifid_we", {31'd0, ifid_we}, {31'd0, f});
        chk(req, "bubble", {31'd0, idex_bubble}, {31'd0, b});
    endtask

    task automatic t_reset;
        rst = 1'b1; id_instr = ADDI; pc_q = PC0; ex_taken = 1'b0; ex_target = '0;
        tick; tick;
        rst = 1'b0; #1;
        ctl3("R1", 1'b1, 1'b1, 1'b0);
        chk("R1", "halted", {31'd0, halted}, 32'd0);
        chk("R7", "ex_instr pass", ex_instr, ADDI);
        chk("R10", "pc_next seq", pc_next, PC0 + 32'd4);
        tick;
    endtask

    task automatic t_xfer(input logic [31:0] w, input logic tk, input logic [31:0] tgt, input logic [31:0] exp);
        id_instr = w; ex_taken = 1'b0; ex_target = '0; #1;
        ctl3("R2", 1'b0, 1'b0, 1'b0);
        chk("R7", "issue word", ex_instr, w);
        tick;
        ex_taken = tk; ex_target = tgt; #1;
        ctl3("R3", 1'b0, 1'b0, 1'b1);
        chk("R7", "bubble word", ex_instr, NOP);
        tick;
        ex_taken = ~tk; ex_target = 32'hDEAD_BEE0; #1;
        ctl3("R3", 1'b0, 1'b0, 1'b1);
        tick;
        #1;
        ctl3("R3", 1'b1, 1'b1, 1'b1);
        chk("R4", "redirect", pc_next, exp);
        tick;
        id_instr = ADDI; ex_taken = 1'b0; #1;
        ctl3("R3", 1'b1, 1'b1, 1'b0);
        tick;
    endtask

    task automatic t_load(input logic [2:0] f3);
        id_instr = mk(7'b0000011, f3); #1;
        ctl3("R5", 1'b0, 1'b0, 1'b0);
        tick;
        #1;
        ctl3("R5", 1'b1, 1'b1, 1'b1);
        chk("R5", "pc_next", pc_next, PC0 + 32'd4);
        tick;
        id_instr = ADDI; #1;
        ctl3("R5", 1'b1, 1'b1, 1'b0);
        tick;
    endtask

    task automatic t_plain(input logic [31:0] w);
        id_instr = w; #1;
        ctl3("R6", 1'b1, 1'b1, 1'b0);
        chk("R10", "pc_next", pc_next, PC0 + 32'd4);
        tick;
        #1;
        ctl3("R6", 1'b1, 1'b1, 1'b0);
        tick;
    endtask

    task automatic t_ignore;
        id_instr = mk(7'b1101111, 3'b000); #1;
        tick;
        id_instr = 32'h0; ex_taken = 1'b1; ex_target = 32'h0000_0400; #1;
        ctl3("R8", 1'b0, 1'b0, 1'b1);
        tick;
        id_instr = mk(7'b0000011, 3'b010); #1;
        ctl3("R8", 1'b0, 1'b0, 1'b1);
        tick;
        id_instr = mk(7'b1100011, 3'b000); #1;
        ctl3("R8", 1'b1, 1'b1, 1'b1);
        chk("R8", "redirect", pc_next, 32'h0000_0400);
        tick;
        id_instr = ADDI; ex_taken = 1'b0; #1;
        ctl3("R8", 1'b1, 1'b1, 1'b0);
        chk("R8", "halted", {31'd0, halted}, 32'd0);
        tick;
    endtask

    task automatic t_halt;
        id_instr = 32'h0; #1;
        ctl3("R9", 1'b0, 1'b0, 1'b1);
        chk("R9", "halt not yet", {31'd0, halted}, 32'd0);
        tick;
        id_instr = ADDI; #1;
        chk("R9", "halted", {31'd0, halted}, 32'd1);
        ctl3("R9", 1'b0, 1'b0, 1'b1);
        chk("R7", "halt word", ex_instr, NOP);
        tick;
        id_instr = mk(7'b0000011, 3'b000); #1;
        ctl3("R9", 1'b0, 1'b0, 1'b1);
        tick;
        rst = 1'b1; tick; rst = 1'b0; id_instr = ADDI; #1;
        chk("R9", "cleared", {31'd0, halted}, 32'd0);
        ctl3("R1", 1'b1, 1'b1, 1'b0);
        tick;
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset;
        t_xfer(mk(7'b1101111, 3'b000), 1'b1, 32'h0000_0800, 32'h0000_0800);
        t_xfer(mk(7'b1100011, 3'b000), 1'b0, 32'h0000_0900, PC0 + 32'd4);
        t_xfer(mk(7'b1100011, 3'b111), 1'b1, 32'h0000_0A00, 32'h0000_0A00);
        t_xfer(mk(7'b1100111, 3'b000), 1'b1, 32'h0000_0B04, 32'h0000_0B04);
        t_xfer(mk(7'b1100011, 3'b001), 1'b0, 32'h0000_0C00, PC0 + 32'd4);
        t_load(3'b010);
        t_load(3'b000);
        t_load(3'b101);
        t_plain(mk(7'b1100011, 3'b010));
        t_plain(mk(7'b0000011, 3'b011));
        t_plain(mk(7'b1100111, 3'b001));
        t_plain(32'h0010_A023);
        t_plain(32'h0020_81B3);
        t_ignore;
        t_halt;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule